// File: doc/BRIEF.md
# Line Event Qualification Sequencer

This block sits behind the analog detectors of a telephone line interface. It decides whether a burst of line activity was a genuine on-hook polarity reversal, a qualified ring, or a transient such as an off-hook edge. A line-activity detector fires on any large swing of the line in either direction. When its synchronized level rises, the block opens a qualification window. While the window is open, it samples the ring-qualified flag, the line-polarity level and the line-in-use level on each 1 ms tick.

A change of polarity alone does not count as a reversal. When a tick sample shows a polarity that differs from the last stable polarity, the block starts a stability check. The new polarity must hold on every tick sample for a minimum time before the reversal is confirmed. A polarity that flips back before then is reported as a transient. Ring and line-in-use indications raised during the stability check are ignored, because a settling polarity transition can set them off.

Each event ends with a one-cycle report that carries a two-bit class code. A confirmed reversal also raises a strobe and updates the stable polarity output. Window length, stability time and the quiet time that closes a window early are parameters counted in ticks.

Top module: `line_evt_qualifier`

## Requirements
- R1: Every detector input passes through a two-flop synchronizer. A rising edge of the synchronized activity level opens a qualification window while the block is idle. An activity pulse with no other indication produces one report of class 2'b00 (none).
- R2: After reset, `evt_class` is 2'b00, `evt_valid` and `rev_pulse` are 0, and `pol_stable` equals the level on `pol_raw`, captured within three cycles of reset release.
- R3: An open window closes with a report on the QUIET_MS-th consecutive tick on which the synchronized activity level is low.
- R4: A window closes with a report on its WIN_MS-th tick at most. If activity is still high in the report cycle, a new window opens at once without a fresh rising edge.
- R5: A reversal is confirmed when the tick-sampled polarity differs from `pol_stable` on STAB_MS+1 consecutive ticks, counted from the first differing sample. The report then has class 2'b01, `rev_pulse` is high in the same cycle as `evt_valid`, and `pol_stable` takes the new level.
- R6: Reversal qualification works the same way for a change from 1 to 0 and for a change from 0 to 1.
- R7: A polarity that returns to the `pol_stable` level before confirmation is reported as class 2'b11 (transient). `pol_stable` is left unchanged and no `rev_pulse` is raised.
- R8: Ring and line-in-use samples taken during the stability check do not affect the class of the report.
- R9: A window that closes without a polarity change reports class 2'b10 (ring) if the ring-qualified flag was sampled high. Otherwise it reports 2'b11 if line-in-use was sampled high, and 2'b00 if neither was.
- R10: `evt_valid` is high for exactly one cycle per report. `evt_class` keeps its value between reports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_ms | input | 1 | One-cycle 1 ms sampling strobe, synchronous to clk |
| act_raw | input | 1 | Asynchronous line-activity detector level |
| pol_raw | input | 1 | Asynchronous line-polarity level |
| liu_raw | input | 1 | Asynchronous line-in-use level |
| ring_ok_raw | input | 1 | Asynchronous qualified-ring flag |
| evt_valid | output | 1 | One-cycle report strobe |
| evt_class | output | 2 | Class of the last report: 00 none, 01 reversal, 10 ring, 11 transient |
| rev_pulse | output | 1 | One-cycle strobe on a confirmed reversal |
| pol_stable | output | 1 | Last confirmed stable polarity |

## Verification
The assertions check on every cycle that a reversal strobe appears only together with a report of class 01 and never without one. They also check that the stable polarity moves only with that strobe, that a report lasts one cycle, that the class holds between reports, and that the tick counters stay inside their limits. Only the bench scenarios can show the timing and class decisions: the stability latency counted in ticks, the early close after the quiet time, the window restart under continuous activity, reversals in both directions, and that ring and line-in-use indications raised during a settling reversal do not change its class.

// File: rtl/lq_pkg.sv
package lq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_STAB   = 2'd2,
        ST_REPORT = 2'd3
    } lq_state_e;

    typedef enum logic [1:0] {
        EVT_NONE  = 2'b00,
        EVT_REV   = 2'b01,
        EVT_RING  = 2'b10,
        EVT_TRANS = 2'b11
    } lq_class_e;

    localparam int LQ_NUM_INPUTS = 4;
    localparam int LQ_SETTLE_W   = 2;

endpackage

// File: rtl/lq_sync2.sv
module lq_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] sync_q, sync_d;

    always_comb begin
        meta_d = d;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/lq_tick_cnt.sv
module lq_tick_cnt #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_last = (cnt_q == LAST);

    // R4: tick counters never run past their limit
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/line_evt_qualifier.sv
module line_evt_qualifier
    import lq_pkg::*;
#(
    parameter int WIN_MS   = 100,
    parameter int STAB_MS  = 50,
    parameter int QUIET_MS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       act_raw,
    input  logic       pol_raw,
    input  logic       liu_raw,
    input  logic       ring_ok_raw,
    output logic       evt_valid,
    output logic [1:0] evt_class,
    output logic       rev_pulse,
    output logic       pol_stable
);

    localparam logic [LQ_SETTLE_W-1:0] SETTLE_DONE = '1;

    typedef struct packed {
        lq_state_e               state;
        lq_class_e               cls;
        logic                    valid;
        logic                    rev;
        logic                    pol;
        logic                    act_prev;
        logic                    ring_seen;
        logic                    liu_seen;
        logic [LQ_SETTLE_W-1:0]  settle;
    } lq_regs_t;

    lq_regs_t r_q, r_d;

    // synchronized detector levels
    logic [LQ_NUM_INPUTS-1:0] sync_vec;
    logic act_s, pol_s, liu_s, ring_s;

    lq_sync2 #(.WIDTH(LQ_NUM_INPUTS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({act_raw, pol_raw, liu_raw, ring_ok_raw}),
        .q     (sync_vec)
    );

    assign {act_s, pol_s, liu_s, ring_s} = sync_vec;

    // tick counters for window, quiet time and stability time
    logic win_clr, win_inc, win_last;
    logic quiet_clr, quiet_inc, quiet_last;
    logic stab_clr, stab_inc, stab_last;

    always_comb begin
        win_clr   = (r_q.state != ST_WINDOW);
        win_inc   = (r_q.state == ST_WINDOW) && tick_ms;
        quiet_clr = (r_q.state != ST_WINDOW) || act_s;
        quiet_inc = (r_q.state == ST_WINDOW) && tick_ms && !act_s;
        stab_clr  = (r_q.state != ST_STAB);
        stab_inc  = (r_q.state == ST_STAB) && tick_ms;
    end

    lq_tick_cnt #(.LIMIT(WIN_MS)) u_win_cnt (
        .clk(clk), .rst_n(rst_n), .clr(win_clr), .inc(win_inc), .at_last(win_last)
    );

    lq_tick_cnt #(.LIMIT(QUIET_MS)) u_quiet_cnt (
        .clk(clk), .rst_n(rst_n), .clr(quiet_clr), .inc(quiet_inc), .at_last(quiet_last)
    );

    lq_tick_cnt #(.LIMIT(STAB_MS)) u_stab_cnt (
        .clk(clk), .rst_n(rst_n), .clr(stab_clr), .inc(stab_inc), .at_last(stab_last)
    );

    function automatic lq_class_e classify(input logic ring_hit, input logic liu_hit);
        if (ring_hit)     return EVT_RING;
        else if (liu_hit) return EVT_TRANS;
        else              return EVT_NONE;
    endfunction

    logic settled;
    logic act_rise;
    logic ring_acc, liu_acc;

    always_comb begin
        settled  = (r_q.settle == SETTLE_DONE);
        act_rise = act_s && !r_q.act_prev;
        ring_acc = r_q.ring_seen || ring_s;
        liu_acc  = r_q.liu_seen || liu_s;

        r_d          = r_q;
        r_d.valid    = 1'b0;
        r_d.rev      = 1'b0;
        r_d.act_prev = act_s;

        // the stable polarity follows the synchronizer until it has filled
        if (!settled) begin
            r_d.settle = r_q.settle + 1'b1;
            r_d.pol    = pol_s;
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (settled && act_rise) begin
                    r_d.state     = ST_WINDOW;
                    r_d.ring_seen = 1'b0;
                    r_d.liu_seen  = 1'b0;
                end
            end

            ST_WINDOW: begin
                if (tick_ms) begin
                    r_d.ring_seen = ring_acc;
                    r_d.liu_seen  = liu_acc;
                    if (pol_s != r_q.pol) begin
                        r_d.state = ST_STAB;
                    end else if (win_last || (quiet_last && !act_s)) begin
                        r_d.state = ST_REPORT;
                        r_d.valid = 1'b1;
                        r_d.cls   = classify(ring_acc, liu_acc);
                    end
                end
            end

            ST_STAB: begin
                // ring and line-in-use are deliberately not sampled here
                if (tick_ms) begin
                    if (pol_s == r_q.pol) begin
                        r_d.state = ST_REPORT;
                        r_d.valid = 1'b1;
                        r_d.cls   = EVT_TRANS;
                    end else if (stab_last) begin
                        r_d.state = ST_REPORT;
                        r_d.valid = 1'b1;
                        r_d.rev   = 1'b1;
                        r_d.cls   = EVT_REV;
                        r_d.pol   = pol_s;
                    end
                end
            end

            ST_REPORT: begin
                if (act_s) begin
                    r_d.state     = ST_WINDOW;
                    r_d.ring_seen = 1'b0;
                    r_d.liu_seen  = 1'b0;
                end else begin
                    r_d.state = ST_IDLE;
                end
            end

            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.cls       <= EVT_NONE;
            r_q.valid     <= 1'b0;
            r_q.rev       <= 1'b0;
            r_q.pol       <= 1'b0;
            r_q.act_prev  <= 1'b0;
            r_q.ring_seen <= 1'b0;
            r_q.liu_seen  <= 1'b0;
            r_q.settle    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign evt_valid  = r_q.valid;
    assign evt_class  = r_q.cls;
    assign rev_pulse  = r_q.rev;
    assign pol_stable = r_q.pol;

    // R5: a reversal strobe always comes with a reversal report
    assert_rev_has_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rev_pulse |-> (evt_valid && evt_class == EVT_REV));

    // R5: a reversal report always carries the strobe
    assert_rev_report_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_class == EVT_REV) |-> rev_pulse);

    // R7: once settled, the stable polarity moves only on a confirmed reversal
    assert_pol_moves_on_rev_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $past(settled) && (pol_stable != $past(pol_stable))) |-> rev_pulse);

    // R10: a report lasts a single cycle
    assert_valid_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

    // R10: the class holds between reports
    assert_class_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> (evt_class == $past(evt_class)));

endmodule

// File: tb/line_evt_qualifier_tb.sv
`timescale 1ns/1ps
module line_evt_qualifier_tb;

    localparam int WIN   = 100;
    localparam int STAB  = 50;
    localparam int QUIET = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic act_raw = 1'b0, pol_raw = 1'b1, liu_raw = 1'b0, ring_ok_raw = 1'b0;
    logic evt_valid, rev_pulse, pol_stable;
    logic [1:0] evt_class;

    always #2.5 clk = ~clk;

    line_evt_qualifier #(.WIN_MS(WIN), .STAB_MS(STAB), .QUIET_MS(QUIET)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .act_raw(act_raw), .pol_raw(pol_raw), .liu_raw(liu_raw), .ring_ok_raw(ring_ok_raw),
        .evt_valid(evt_valid), .evt_class(evt_class), .rev_pulse(rev_pulse), .pol_stable(pol_stable)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int tick_num = 0;
    int report_tick = 0;
    int n_reports = 0;
    bit finished = 0;

    logic [1:0] exp_cls_q[$];
    bit         exp_rev_q[$];
    bit         exp_pol_q[$];

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        n_tests++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic expect_report(input logic [1:0] cls, input bit rev, input bit pol);
        exp_cls_q.push_back(cls);
        exp_rev_q.push_back(rev);
        exp_pol_q.push_back(pol);
    endtask

    // tick driver: one-cycle strobe every four clocks
    initial begin
        @(posedge rst_n);
        forever begin
            repeat (3) @(negedge clk);
            tick_ms = 1'b1;
            tick_num++;
            @(negedge clk);
            tick_ms = 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rev_pulse && !evt_valid)
                chk("R5 strobe without report", 1, 0);
            if (evt_valid) begin
                n_reports++;
                report_tick = tick_num;
                if (exp_cls_q.size() == 0) begin
                    chk("R10 unexpected report", 1, 0);
                end else begin
                    chk("R9 report class", int'(evt_class), int'(exp_cls_q.pop_front()));
                    chk("R5 reversal strobe", int'(rev_pulse), int'(exp_rev_q.pop_front()));
                    chk("R7 stable polarity", int'(pol_stable), int'(exp_pol_q.pop_front()));
                end
            end
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) @(negedge tick_ms);
    endtask

    task automatic wait_report();
        int start;
        start = n_reports;
        while (n_reports == start) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    int t0;
    int t1;
    int got;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2: reset state and polarity capture
        chk("R2 class after reset", int'(evt_class), 0);
        chk("R2 valid after reset", int'(evt_valid), 0);
        chk("R2 strobe after reset", int'(rev_pulse), 0);
        chk("R2 polarity captured", int'(pol_stable), 1);

        // R1, R3: bare activity pulse gives class none, quiet time closes window
        expect_report(2'b00, 1'b0, 1'b1);
        @(negedge tick_ms);
        act_raw = 1'b1;
        wait_ticks(3);
        act_raw = 1'b0;
        t0 = tick_num;
        wait_report();
        chk_range("R3 quiet close latency", report_tick - t0, QUIET, QUIET + 1);
        chk("R10 valid low after report", int'(evt_valid), 0);

        // R5: reversal from 1 to 0
        expect_report(2'b01, 1'b1, 1'b0);
        @(negedge tick_ms);
        act_raw = 1'b1;
        pol_raw = 1'b0;
        t0 = tick_num;
        wait_ticks(3);
        act_raw = 1'b0;
        wait_report();
        chk_range("R5 stability latency", report_tick - t0, STAB + 1, STAB + 2);
        chk("R10 class held after reversal", int'(evt_class), 1);

        // R6, R8: reversal from 0 to 1 with ring and line-in-use during settling
        expect_report(2'b01, 1'b1, 1'b1);
        @(negedge tick_ms);
        act_raw = 1'b1;
        pol_raw = 1'b1;
        t0 = tick_num;
        wait_ticks(3);
        act_raw = 1'b0;
        wait_ticks(3);
        ring_ok_raw = 1'b1;
        liu_raw = 1'b1;
        wait_ticks(30);
        ring_ok_raw = 1'b0;
        liu_raw = 1'b0;
        wait_report();
        chk_range("R6 rising reversal latency", report_tick - t0, STAB + 1, STAB + 2);
        chk("R8 class unaffected by ring", int'(evt_class), 1);

        // R7: polarity reverts before the stability time
        expect_report(2'b11, 1'b0, 1'b1);
        @(negedge tick_ms);
        act_raw = 1'b1;
        pol_raw = 1'b0;
        wait_ticks(3);
        act_raw = 1'b0;
        wait_ticks(17);
        pol_raw = 1'b1;
        wait_report();
        chk("R7 polarity unchanged", int'(pol_stable), 1);

        // R9: ring flag during window
        ring_ok_raw = 1'b1;
        expect_report(2'b10, 1'b0, 1'b1);
        @(negedge tick_ms);
        act_raw = 1'b1;
        wait_ticks(3);
        act_raw = 1'b0;
        wait_report();
        ring_ok_raw = 1'b0;
        repeat (4) @(negedge clk);

        // R9: line-in-use only
        liu_raw = 1'b1;
        expect_report(2'b11, 1'b0, 1'b1);
        @(negedge tick_ms);
        act_raw = 1'b1;
        wait_ticks(3);
        act_raw = 1'b0;
        wait_report();
        liu_raw = 1'b0;
        repeat (4) @(negedge clk);

        // R4: activity held past the window length, then restart
        expect_report(2'b00, 1'b0, 1'b1);
        expect_report(2'b00, 1'b0, 1'b1);
        @(negedge tick_ms);
        act_raw = 1'b1;
        t0 = tick_num;
        got = n_reports;
        while (n_reports == got) @(negedge clk);
        chk_range("R4 window length", report_tick - t0, WIN, WIN + 1);
        repeat (3) @(negedge clk);
        act_raw = 1'b0;
        t1 = tick_num;
        while (n_reports == got + 1 && tick_num < t1 + QUIET + 6) @(negedge clk);
        chk("R4 window restarted", n_reports - got, 2);
        repeat (8) @(negedge clk);

        chk("R10 all expected reports seen", exp_cls_q.size(), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule